// File: doc/BRIEF.md
# H-Bridge Gate Control and Fault Latch

This block is the digital heart of a two-leg H-bridge motor driver. It reads two direction inputs, an active-high disable, an active-high enable, and the flags that the analog front end raises for overcurrent, overtemperature, current limit, supply undervoltage and a below-ground voltage on each leg. From these it produces registered high-side and low-side gate enables for both legs, plus an active-low status flag. The flag is low whenever the bridge is forced off.

When the bridge is enabled, each leg follows its own direction input. Overcurrent and overtemperature trips are stored until the host toggles the disable or enable input. An undervoltage trip releases by itself when the supply recovers. A current-limit event chops the bridge off for a fixed number of cycles, and the limit flag is then ignored for a blanking window. While the bridge is off, a leg whose voltage sits below ground gets its low side switched on to carry the free-wheel current.

Every asynchronous input passes through a two-flop synchroniser. A gate change therefore reaches the pins three clock cycles after the input changes. A leg that swaps from one side to the other takes one extra cycle, during which both of its gates are off.

Top module: `hbridge_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, all four gate enables are 0 and `flag_n_o` is 0.
- R2: When `dis_i` is 1 or `en_i` is 0, both high sides are off. Each low side is off unless its leg's below-ground flag is set. `flag_n_o` is 0.
- R3: When enabled and with no fault, each leg follows its direction input. Direction 1 turns the high side on and the low side off, and direction 0 does the reverse. `flag_n_o` is 1.
- R4: The high and low gates of one leg are never 1 together. A gate of a leg only turns on if the other gate of that leg was 0 in the previous cycle.
- R5: A pulse on `ovc_i` turns all gates off and holds `flag_n_o` at 0 after the pulse has ended. The state clears only on a 1-to-0 transition of `dis_i` or a 0-to-1 transition of `en_i`.
- R6: A pulse on `ovt_i` is stored the same way as an overcurrent and is cleared by a rising edge of `en_i`.
- R7: While `uv_i` is 1, the high sides are off and `flag_n_o` is 0. Normal drive resumes when `uv_i` returns to 0, with no toggle of `dis_i` or `en_i`.
- R8: When `ilim_i` is seen, the bridge is forced off and `flag_n_o` is 0 for exactly OFF_CYC cycles. The bridge then switches back on and the flag returns to 1.
- R9: After each switch-on, `ilim_i` is ignored for BLANK_CYC cycles. With `ilim_i` held at 1, each on-phase therefore lasts BLANK_CYC+1 cycles.
- R10: While the bridge is off, a leg's low side is on exactly while that leg's below-ground flag is 1. While that leg's high side is driven on, the flag is ignored.
- R11: A direction or disable change reaches the gate pins on the third rising clock edge after the input changes. A side swap adds one cycle with both gates of the leg off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a_i | input | 1 | Direction request for leg A |
| dir_b_i | input | 1 | Direction request for leg B |
| dis_i | input | 1 | Disable, active high |
| en_i | input | 1 | Enable, active high |
| ovc_i | input | 1 | Overcurrent comparator flag |
| ovt_i | input | 1 | Overtemperature comparator flag |
| ilim_i | input | 1 | Current-limit comparator flag |
| uv_i | input | 1 | Supply undervoltage flag |
| neg_a_i | input | 1 | Leg A voltage below ground |
| neg_b_i | input | 1 | Leg B voltage below ground |
| hs_a_o | output | 1 | Leg A high-side gate enable |
| ls_a_o | output | 1 | Leg A low-side gate enable |
| hs_b_o | output | 1 | Leg B high-side gate enable |
| ls_b_o | output | 1 | Leg B low-side gate enable |
| flag_n_o | output | 1 | Status flag, low while the bridge is forced off |

## Verification
A fault latch stuck at 1 leaves all gates off and the flag low, and this shows at the next settled check. A latch that fails to hold shows up as drive returning before the disable toggle. A chop counter that is off by one changes the measured low or high width of the status flag by a cycle, so the widths are counted edge by edge. A broken interlock or edge detector shows within one cycle of a side swap, either as both gates of a leg on at once or as a missing gap cycle. The three-cycle pipeline is checked at the exact edge where the gates should change.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int N_LEG = 2;
    localparam int N_IN  = 10;

    // bit positions in the synchronised input vector
    localparam int B_DIR0 = 0;
    localparam int B_DIR1 = 1;
    localparam int B_DIS  = 2;
    localparam int B_EN   = 3;
    localparam int B_OVC  = 4;
    localparam int B_OVT  = 5;
    localparam int B_ILIM = 6;
    localparam int B_UV   = 7;
    localparam int B_NEG0 = 8;
    localparam int B_NEG1 = 9;

    typedef enum logic [1:0] {
        CHOP_RUN   = 2'd0,
        CHOP_OFF   = 2'd1,
        CHOP_BLANK = 2'd2
    } chop_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] stg_d;
        if (s == 0) begin : g_first
            assign stg_d = d_i;
        end else begin : g_next
            assign stg_d = stg_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hb_fault.sv
module hb_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic dis_s_i,
    input  logic en_s_i,
    input  logic ovc_s_i,
    input  logic ovt_s_i,
    output logic trip_o
);
    typedef struct packed {
        logic dis_prev;
        logic en_prev;
        logic oc;
        logic ot;
    } flt_t;

    flt_t f_d, f_q;
    logic clr;

    always_comb begin
        f_d = f_q;
        // release event: disable falling or enable rising
        clr = (f_q.dis_prev & ~dis_s_i) | (~f_q.en_prev & en_s_i);
        f_d.dis_prev = dis_s_i;
        f_d.en_prev  = en_s_i;
        f_d.oc = (f_q.oc & ~clr) | ovc_s_i;
        f_d.ot = (f_q.ot & ~clr) | ovt_s_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign trip_o = f_q.oc | f_q.ot;
endmodule

// File: rtl/hb_chop.sv
module hb_chop
    import hb_pkg::*;
#(
    parameter int OFF_CYC   = 1600,
    parameter int BLANK_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic ilim_s_i,
    output logic allow_o
);
    localparam int MAXC = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        chop_e         st;
        logic [CW-1:0] cnt;
    } ch_t;

    ch_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!active_i) begin
            c_d.st  = CHOP_BLANK;
            c_d.cnt = CW'(BLANK_CYC - 1);
        end else begin
            unique case (c_q.st)
                CHOP_RUN: begin
                    if (ilim_s_i) begin
                        c_d.st  = CHOP_OFF;
                        c_d.cnt = CW'(OFF_CYC - 1);
                    end
                end
                CHOP_OFF: begin
                    if (c_q.cnt == '0) begin
                        c_d.st  = CHOP_BLANK;
                        c_d.cnt = CW'(BLANK_CYC - 1);
                    end else begin
                        c_d.cnt = c_q.cnt - 1'b1;
                    end
                end
                default: begin
                    if (c_q.cnt == '0) c_d.st  = CHOP_RUN;
                    else               c_d.cnt = c_q.cnt - 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st  <= CHOP_BLANK;
            c_q.cnt <= CW'(BLANK_CYC - 1);
        end else begin
            c_q <= c_d;
        end
    end

    assign allow_o = (c_q.st != CHOP_OFF);
endmodule

// File: rtl/hb_leg.sv
module hb_leg (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi_i,
    input  logic want_lo_i,
    output logic hs_o,
    output logic ls_o
);
    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        // a side may only turn on once the opposite side is registered off
        g_d.hs = want_hi_i & ~g_q.ls;
        g_d.ls = want_lo_i & ~g_q.hs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign hs_o = g_q.hs;
    assign ls_o = g_q.ls;
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OFF_CYC     = 1600,
    parameter int BLANK_CYC   = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_a_i,
    input  logic dir_b_i,
    input  logic dis_i,
    input  logic en_i,
    input  logic ovc_i,
    input  logic ovt_i,
    input  logic ilim_i,
    input  logic uv_i,
    input  logic neg_a_i,
    input  logic neg_b_i,
    output logic hs_a_o,
    output logic ls_a_o,
    output logic hs_b_o,
    output logic ls_b_o,
    output logic flag_n_o
);
    logic [N_IN-1:0]  raw, syn;
    logic [N_LEG-1:0] dir_s, neg_s, want_hi, want_lo, hs, ls;
    logic             trip, allow, enabled, active, drive;

    typedef struct packed {
        logic flag_n;
    } top_t;

    top_t t_d, t_q;

    assign raw[B_DIR0] = dir_a_i;
    assign raw[B_DIR1] = dir_b_i;
    assign raw[B_DIS]  = dis_i;
    assign raw[B_EN]   = en_i;
    assign raw[B_OVC]  = ovc_i;
    assign raw[B_OVT]  = ovt_i;
    assign raw[B_ILIM] = ilim_i;
    assign raw[B_UV]   = uv_i;
    assign raw[B_NEG0] = neg_a_i;
    assign raw[B_NEG1] = neg_b_i;

    hb_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw),
        .q_o  (syn)
    );

    hb_fault u_fault (
        .clk    (clk),
        .rst_n  (rst_n),
        .dis_s_i(syn[B_DIS]),
        .en_s_i (syn[B_EN]),
        .ovc_s_i(syn[B_OVC]),
        .ovt_s_i(syn[B_OVT]),
        .trip_o (trip)
    );

    hb_chop #(.OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC)) u_chop (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .ilim_s_i(syn[B_ILIM]),
        .allow_o (allow)
    );

    assign dir_s = {syn[B_DIR1], syn[B_DIR0]};
    assign neg_s = {syn[B_NEG1], syn[B_NEG0]};

    always_comb begin
        enabled = ~syn[B_DIS] & syn[B_EN];
        active  = enabled & ~trip & ~syn[B_UV];
        drive   = active & allow;
        for (int i = 0; i < N_LEG; i++) begin
            want_hi[i] = drive & dir_s[i];
            // free-wheel assist only while the bridge is not driving
            want_lo[i] = drive ? ~dir_s[i] : neg_s[i];
        end
        t_d.flag_n = drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    for (genvar g = 0; g < N_LEG; g++) begin : g_leg
        hb_leg u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .want_hi_i(want_hi[g]),
            .want_lo_i(want_lo[g]),
            .hs_o     (hs[g]),
            .ls_o     (ls[g])
        );
    end

    assign hs_a_o   = hs[0];
    assign ls_a_o   = ls[0];
    assign hs_b_o   = hs[1];
    assign ls_b_o   = ls[1];
    assign flag_n_o = t_q.flag_n;
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic dis_i,
    input logic en_i,
    input logic uv_i,
    input logic hs_a_o,
    input logic ls_a_o,
    input logic hs_b_o,
    input logic ls_b_o,
    input logic flag_n_o
);
    // pipeline depth of 3 matches the default two synchroniser stages plus the gate register

    assert_no_shoot_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a_o && ls_a_o));
    assert_no_shoot_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_b_o && ls_b_o));
    assert_gap_ls_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_a_o) |-> !$past(hs_a_o));
    assert_gap_hs_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_a_o) |-> !$past(ls_a_o));
    assert_gap_ls_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_b_o) |-> !$past(hs_b_o));
    assert_gap_hs_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_b_o) |-> !$past(ls_b_o));
    assert_disable_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dis_i, 3) || !$past(en_i, 3)) |-> (!hs_a_o && !hs_b_o));
    assert_uv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(uv_i, 3) |-> (!hs_a_o && !hs_b_o));
    assert_drive_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_a_o || hs_b_o) |-> flag_n_o);
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dis_i   (dis_i),
    .en_i    (en_i),
    .uv_i    (uv_i),
    .hs_a_o  (hs_a_o),
    .ls_a_o  (ls_a_o),
    .hs_b_o  (hs_b_o),
    .ls_b_o  (ls_b_o),
    .flag_n_o(flag_n_o)
);

// File: tb/tb_hbridge_ctrl.sv
module tb_hbridge_ctrl;
    localparam int OFF_CYC   = 8;
    localparam int BLANK_CYC = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic dir_a, dir_b, dis, en, ovc, ovt, ilim, uv, neg_a, neg_b;
    logic hs_a, ls_a, hs_b, ls_b, flag_n;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    hbridge_ctrl #(.SYNC_STAGES(2), .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC)) dut (
        .clk(clk), .rst_n(rst_n),
        .dir_a_i(dir_a), .dir_b_i(dir_b), .dis_i(dis), .en_i(en),
        .ovc_i(ovc), .ovt_i(ovt), .ilim_i(ilim), .uv_i(uv),
        .neg_a_i(neg_a), .neg_b_i(neg_b),
        .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b),
        .flag_n_o(flag_n)
    );

    // vector: dis en dir_a dir_b | hs_a ls_a hs_b ls_b flag_n
    localparam logic [8:0] VEC [8] = '{
        9'b0110_10011,
        9'b0101_01101,
        9'b0100_01011,
        9'b0111_10101,
        9'b1110_00000,
        9'b0010_00000,
        9'b1001_00000,
        9'b0110_10011
    };

    function automatic logic [4:0] obs();
        return {hs_a, ls_a, hs_b, ls_b, flag_n};
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lo_w, hi_w;
        rst_n = 1'b0;
        {dir_a, dir_b, ovc, ovt, ilim, uv, neg_a, neg_b} = '0;
        dis = 1'b1;
        en  = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R1 in reset", obs(), 5'b00000);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 chk("R1 after reset", obs(), 5'b00000);

        // truth table walk
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            {dis, en, dir_a, dir_b} = VEC[v][8:5];
            settle();
            chk(VEC[v][0] ? "R3 enabled truth table" : "R2 disabled",
                obs(), VEC[v][4:0]);
        end

        // R11 latency and R4 gap cycle: forward, leg A swaps to low side
        @(negedge clk) dir_a = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk("R11 no change after two edges", obs(), 5'b10011);
        @(posedge clk);
        #1 chk("R4 gap cycle both off", obs(), 5'b00011);
        @(posedge clk);
        #1 chk("R11 low side on after gap", obs(), 5'b01011);
        @(negedge clk) dir_a = 1'b1;
        settle();

        // R5 overcurrent latch cleared by disable falling
        @(negedge clk) ovc = 1'b1;
        repeat (2) @(negedge clk);
        ovc = 1'b0;
        settle();
        chk("R5 overcurrent tripped", obs(), 5'b00000);
        repeat (20) @(posedge clk);
        #1 chk("R5 overcurrent still stored", obs(), 5'b00000);
        @(negedge clk) dis = 1'b1;
        settle();
        @(negedge clk) dis = 1'b0;
        settle();
        chk("R5 cleared by disable falling", obs(), 5'b10011);

        // R6 overtemperature latch cleared by enable rising
        @(negedge clk) ovt = 1'b1;
        repeat (2) @(negedge clk);
        ovt = 1'b0;
        settle();
        repeat (10) @(posedge clk);
        #1 chk("R6 overtemperature stored", obs(), 5'b00000);
        @(negedge clk) en = 1'b0;
        settle();
        @(negedge clk) en = 1'b1;
        settle();
        chk("R6 cleared by enable rising", obs(), 5'b10011);

        // R7 undervoltage self-clearing
        @(negedge clk) uv = 1'b1;
        settle();
        chk("R7 undervoltage off", obs(), 5'b00000);
        @(negedge clk) uv = 1'b0;
        settle();
        chk("R7 undervoltage recovered", obs(), 5'b10011);

        // R8 / R9 chopping with current limit held
        @(negedge clk) ilim = 1'b1;
        for (int i = 0; i < 100 && flag_n == 1'b1; i++) @(negedge clk);
        lo_w = 0;
        for (int i = 0; i < 100 && flag_n == 1'b0; i++) begin
            if (hs_a) begin
                errors++;
                $display("FAIL R8 high side on during off time actual=1 expected=0");
            end
            lo_w++;
            @(negedge clk);
        end
        hi_w = 0;
        for (int i = 0; i < 100 && flag_n == 1'b1; i++) begin
            hi_w++;
            @(negedge clk);
        end
        chk_int("R8 off time width", lo_w, OFF_CYC);
        chk_int("R9 blanking on width", hi_w, BLANK_CYC + 1);
        ilim = 1'b0;
        settle();
        repeat (20) @(posedge clk);
        #1 chk("R8 running after limit released", obs(), 5'b10011);

        // R10 free-wheel assist
        @(negedge clk) dis = 1'b1;
        settle();
        @(negedge clk) neg_a = 1'b1;
        settle();
        chk("R10 leg A assist", obs(), 5'b01000);
        @(negedge clk) neg_b = 1'b1;
        settle();
        chk("R10 both legs assist", obs(), 5'b01010);
        @(negedge clk) {neg_a, neg_b} = 2'b00;
        settle();
        chk("R10 assist ends", obs(), 5'b00000);
        @(negedge clk) begin dis = 1'b0; neg_a = 1'b1; end
        settle();
        chk("R10 flag ignored while driving", obs(), 5'b10011);
        @(negedge clk) neg_a = 1'b0;
        settle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule